// File: doc/BRIEF.md
# Sequential Burst Slave Address Generator

This block sits on the slave side of a synchronous external bus. It turns bus data requests into addresses and strobes for a local memory port. A transfer opens with an initial access: a read or write strobe with the burst line low. On that access the block takes the address from the bus. If the burst line is high on the requests that follow, the block advances its own copy of the address by one after every completed beat. The master never drives the advanced address on the bus. The master drops the burst line on the final request, so the block detects the last beat by seeing a strobe while the burst line is low and a burst is open.

The local memory can slow a transfer down with its ready input. While ready is low, the block pulls the bus acknowledge low. The beat address stays where it is until ready comes back.

The controller has four states. `S_IDLE` waits for an initial access. `S_HOLD` is an initial access that is being stalled. `S_LINK` follows a completed first beat, where either a burst continues or a new access begins. `S_BURST` is an open burst. The transitions are:
- idle-to-link: an initial access completes.
- idle-to-hold: an initial access is stalled.
- hold-to-link: the stall ends.
- hold-to-idle: the strobe is withdrawn.
- link-to-burst: a strobe arrives with burst high.
- link-to-idle: a cycle with no strobe and burst low.
- link-to-link: a new initial access completes.
- burst-to-idle: the last beat completes.

Top module: `seqburst_addr_gen`

## Requirements
- R1: After reset, `in_burst` is 0. While idle, `mem_addr` equals `bus_addr`.
- R2: An access that is not part of an open burst presents `bus_addr` on `mem_addr` in the same cycle. An access is not part of an open burst when a strobe (`bus_rd` or `bus_wr` high) arrives with `bus_burst` low.
- R3: Each completed beat (strobe high and `mem_ready` high) of a burst makes the next beat's `mem_addr` one greater than the previous beat's.
- R4: During burst beats (`bus_burst` high after the initial access), `bus_addr` has no effect on `mem_addr`.
- R5: In an open burst, a strobe with `bus_burst` low is the last beat. It uses the next sequential address. Once it completes, `in_burst` returns to 0 and the next access takes its address from the bus.
- R6: While a strobe is high and `mem_ready` is low, `bus_ack` is 0 and `mem_addr` holds its value across the stalled cycles.
- R7: An initial access with no burst following it never raises `in_burst`. The following access with `bus_burst` low uses the new `bus_addr`.
- R8: The internal address wraps from all ones to zero with no other effect.
- R9: `mem_rd` and `mem_wr` follow `bus_rd` and `bus_wr` in the same cycle.
- R10: `in_burst` is 1 from the second completed or attempted burst-high request until the last beat completes. A reset during a burst clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Address driven by the master |
| bus_rd | input | 1 | Read request strobe |
| bus_wr | input | 1 | Write request strobe |
| bus_burst | input | 1 | Sequential burst indicator |
| mem_ready | input | 1 | Local memory can complete the beat |
| bus_ack | output | 1 | Acknowledge to the master, low to add wait states |
| mem_addr | output | AW | Address for the local memory |
| mem_rd | output | 1 | Local read strobe |
| mem_wr | output | 1 | Local write strobe |
| in_burst | output | 1 | A burst is open |

## Verification
The checks use several input patterns, each aimed at one kind of fault:
- A four-beat write burst, with garbage on `bus_addr` during the burst-high beats, shows whether the address comes from the counter or leaks from the bus.
- A read burst with wait states on the first beat and on a middle beat shows whether a stall wrongly advances the address.
- Back-to-back single accesses show whether a lone access is mistaken for the start of a burst.
- A burst that starts just below the all-ones address checks the wrap.
- A reset in the middle of a burst checks that the open-burst state is cleared.

// File: rtl/sbag_pkg.sv
package sbag_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_HOLD  = 2'd1,
        S_LINK  = 2'd2,
        S_BURST = 2'd3
    } sbag_state_t;
endpackage

// File: rtl/sbag_counter.sv
module sbag_counter #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] cnt_q
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] base;
    logic [AW-1:0] cnt_d;

    always_comb begin
        base  = load ? load_val : cnt_q;
        cnt_d = step ? base + ONE : base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sbag_fsm.sv
module sbag_fsm
    import sbag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe,
    input  logic        burst,
    input  logic        ready,
    output sbag_state_t state_q,
    output logic        fresh,
    output logic        load,
    output logic        step
);
    sbag_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fresh   = (state_q == S_IDLE) || (state_q == S_LINK && !burst);
        load    = fresh && strobe;
        step    = strobe && ready;
        state_d = state_q;
        if (fresh) begin
            if (strobe) state_d = ready ? S_LINK : S_HOLD;
            else        state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_HOLD: begin
                    if (!strobe)    state_d = S_IDLE;
                    else if (ready) state_d = S_LINK;
                end
                S_LINK: begin
                    if (strobe) state_d = S_BURST;
                end
                S_BURST: begin
                    if (strobe && !burst && ready) state_d = S_IDLE;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seqburst_addr_gen.sv
module seqburst_addr_gen
    import sbag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          bus_burst,
    input  logic          mem_ready,
    output logic          bus_ack,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          in_burst
);
    localparam logic [AW-1:0] ONE = AW'(1);

    sbag_state_t   state_q;
    logic          strobe;
    logic          fresh;
    logic          load;
    logic          step;
    logic [AW-1:0] cnt_q;

    assign strobe = bus_rd | bus_wr;

    sbag_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .burst   (bus_burst),
        .ready   (mem_ready),
        .state_q (state_q),
        .fresh   (fresh),
        .load    (load),
        .step    (step)
    );

    sbag_counter #(.AW(AW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .load_val (bus_addr),
        .cnt_q    (cnt_q)
    );

    always_comb begin
        mem_addr = fresh ? bus_addr : cnt_q;
        mem_rd   = bus_rd;
        mem_wr   = bus_wr;
        bus_ack  = !strobe || mem_ready;
        in_burst = (state_q == S_BURST);
    end

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && mem_ready && !fresh) |=> (cnt_q == $past(cnt_q) + ONE));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !mem_ready && !fresh) |=> $stable(mem_addr));

    a_r5_end: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && strobe && !bus_burst && mem_ready) |=> !in_burst);

    a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh && strobe && mem_ready) |=> !in_burst);

    a_r10_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!fresh && !in_burst && strobe && bus_burst) |=> in_burst);
endmodule

// File: tb/sim_seqburst_addr_gen.sv
module sim_seqburst_addr_gen;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0, bus_burst = 1'b0, mem_ready = 1'b1;
    logic          bus_ack, mem_rd, mem_wr, in_burst;
    logic [AW-1:0] mem_addr;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    seqburst_addr_gen #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_burst(bus_burst), .mem_ready(mem_ready),
        .bus_ack(bus_ack), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .in_burst(in_burst)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, then check the outputs
    task automatic beat(input bit rd, input bit wr, input bit bst, input logic [AW-1:0] a,
                        input bit rdy, input logic [AW-1:0] exp_a, input string tag);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_burst = bst; bus_addr = a; mem_ready = rdy;
        #1;
        chk(mem_addr == exp_a, tag, mem_addr, exp_a);
        chk(bus_ack == (!(rd || wr) || rdy), "R6 ack", bus_ack, !(rd || wr) || rdy);
        chk(mem_rd == rd && mem_wr == wr, "R9 strobes", {mem_rd, mem_wr}, {rd, wr});
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; bus_burst = 0; mem_ready = 1; bus_addr = 16'h0BAD;
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(in_burst == 0, "R1 in_burst at reset", in_burst, 0);
        chk(mem_addr == bus_addr, "R1 addr idle", mem_addr, bus_addr);
        @(negedge clk); rst_n = 1;
        idle_cycle(); #1;
        chk(in_burst == 0, "R1 in_burst after reset", in_burst, 0);
    endtask

    task automatic t_write_burst();
        beat(0, 1, 0, 16'h1200, 1, 16'h1200, "R2 first addr");
        beat(0, 1, 1, 16'hDEAD, 1, 16'h1201, "R4 beat2 ignores bus");
        #1 chk(in_burst == 0, "R10 not yet open", in_burst, 0);
        beat(0, 1, 1, 16'hBEEF, 1, 16'h1202, "R3 beat3");
        chk(in_burst == 1, "R10 open", in_burst, 1);
        beat(0, 1, 0, 16'h7777, 1, 16'h1203, "R5 last beat addr");
        idle_cycle(); #1;
        chk(in_burst == 0, "R5 closed", in_burst, 0);
        beat(1, 0, 0, 16'h4444, 1, 16'h4444, "R5 next from bus");
        idle_cycle();
    endtask

    task automatic t_stall_read();
        beat(1, 0, 0, 16'h0300, 0, 16'h0300, "R6 first stalled");
        beat(1, 0, 0, 16'h0300, 1, 16'h0300, "R6 first held");
        beat(1, 0, 1, 16'hAAAA, 0, 16'h0301, "R6 mid stalled");
        beat(1, 0, 1, 16'hBBBB, 0, 16'h0301, "R6 mid held");
        beat(1, 0, 1, 16'hCCCC, 1, 16'h0301, "R6 mid done");
        beat(1, 0, 1, 16'hDDDD, 1, 16'h0302, "R3 after stall");
        beat(1, 0, 0, 16'hEEEE, 0, 16'h0303, "R6 last stalled");
        beat(1, 0, 0, 16'hEEEE, 1, 16'h0303, "R5 last done");
        idle_cycle(); #1;
        chk(in_burst == 0, "R5 closed after stall", in_burst, 0);
    endtask

    task automatic t_singles();
        beat(1, 0, 0, 16'h0050, 1, 16'h0050, "R7 single a");
        #1 chk(in_burst == 0, "R7 no burst", in_burst, 0);
        beat(0, 1, 0, 16'h0090, 1, 16'h0090, "R7 single b new addr");
        #1 chk(in_burst == 0, "R7 still none", in_burst, 0);
        idle_cycle();
    endtask

    task automatic t_wrap();
        beat(1, 0, 0, 16'hFFFE, 1, 16'hFFFE, "R8 start");
        beat(1, 0, 1, 16'h1111, 1, 16'hFFFF, "R8 top");
        beat(1, 0, 0, 16'h1111, 1, 16'h0000, "R8 wrapped");
        idle_cycle();
    endtask

    task automatic t_reset_mid();
        beat(0, 1, 0, 16'h0600, 1, 16'h0600, "R2 reset test start");
        beat(0, 1, 1, 16'h0000, 1, 16'h0601, "R3 reset test beat");
        beat(0, 1, 1, 16'h0000, 1, 16'h0602, "R3 reset test beat2");
        @(negedge clk); rst_n = 0; bus_rd = 0; bus_wr = 0; bus_burst = 1;
        @(negedge clk); rst_n = 1; bus_burst = 0; bus_addr = 16'h0777; #1;
        chk(in_burst == 0, "R10 reset clears burst", in_burst, 0);
        chk(mem_addr == 16'h0777, "R1 idle after reset", mem_addr, 16'h0777);
    endtask

    initial begin
        t_reset();
        t_write_burst();
        t_stall_read();
        t_singles();
        t_wrap();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule